// File: doc/BRIEF.md
# Cascaded Dual Interrupt Controller

This block joins two eight-line interrupt controllers into one unit with sixteen request inputs and a single interrupt line to the processor. Requests 0 to 7 go to the primary controller and requests 8 to 15 go to the secondary. The secondary reports to the processor only through the primary: while it holds a deliverable request, it marks primary line 2 as pending, the same way a rising edge on that line would. The processor answers a raised interrupt with a one-cycle acknowledge and reads an 8-bit vector in that cycle. The acknowledge goes through both levels when the primary grants line 2. If nothing is left to grant at either level, the vector points at line 7 of that level.

Software reaches the block through a byte-wide register port. Each controller has a command byte and a data byte. Address bit 7 picks the controller and address bit 0 picks command or data. A separate pair of trigger-mode registers sets each line to edge or level triggering, and a fixed mask limits which bits can be written. Each controller has a small command set: an initialisation sequence, mask writes, end-of-interrupt commands and a register-select command. Priority is fixed, and line 0 is the highest.

Top module: `dual_irq_ctrl`

## Requirements
- R1: `irqIn[n]` drives line n mod 8 of the primary for n < 8, and of the secondary for n ≥ 8. Line 0 has the highest priority in each controller. By default, a read of a command byte returns that controller's pending-request bits, with bit k for line k.
- R2: While the secondary has a request it would grant, primary line 2 becomes pending (request bit 2 set) on the next clock edge. This happens whatever the trigger mode of line 2, and the bit stays set after the secondary stops asking.
- R3: After the primary's fourth initialisation word is written with bit 4 set (nested mode), the primary ignores its own in-service bit 2 when it finds the current priority. A higher secondary request can then raise `intOut` while a lower secondary interrupt is in service.
- R4: An acknowledge while the primary grants line k ≠ 2 returns vector primaryBase + k and sets in-service bit k. It also clears request bit k if line k is edge triggered.
- R5: An acknowledge while the primary grants line 2 also acknowledges the secondary's granted line j and returns secondaryBase + j. If the secondary has nothing to grant, it returns secondaryBase + 7.
- R6: An acknowledge while the primary grants nothing returns primaryBase + 7 and changes no state.
- R7: Address 0x4D0 holds the primary trigger-mode byte and 0x4D1 holds the secondary's. Writes are ANDed with 0xF8 (primary) or 0xDE (secondary), and reads return the stored value. Bit k = 1 makes line k level triggered: its request bit follows the input, and an acknowledge does not clear it.
- R8: Addresses 0x20/0x21 select the primary and 0xA0/0xA1 select the secondary, using address bit 7. An odd address writes or reads the mask byte, where bit k = 1 blocks line k.
- R9: A write to any other address changes no state, and a read of any other address returns 0x00.
- R10: `intOut` is high exactly when the primary has an unmasked pending line of higher priority than its highest in-service line.
- R11: The command byte 0x20 clears the highest-priority in-service bit. The byte 0x60|k clears in-service bit k. The byte 0x0B makes command-byte reads return the in-service bits, and 0x0A returns them to request bits.
- R12: A command byte with bit 4 set starts initialisation. The next three data writes set the base (low 3 bits forced to 0), a word that is ignored, and, only if bit 0 of the command was set, the fourth word. Initialisation clears the mask, the in-service bits and the edge-triggered request bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqIn | input | 16 | Interrupt request inputs |
| busAddr | input | 16 | Register port address |
| busWr | input | 1 | Single-byte write strobe |
| busRd | input | 1 | Single-byte read strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, valid in the cycle busRd is high |
| ackStrobe | input | 1 | Interrupt acknowledge, one cycle |
| ackVector | output | 8 | Vector, valid in the cycle ackStrobe is high |
| intOut | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that an acknowledge never falls in the same cycle as a register write, and that writes and reads are never issued together. Both would compete for the in-service bits. They also assume the request inputs are driven from time zero. The stimulus meets these assumptions: each register access, each acknowledge and each input change takes its own cycles, and the inputs move only on the falling clock edge. Nested-mode preemption and the line-7 fallbacks are reached only through ordinary acknowledges and mask writes.

// File: rtl/dic_pkg.sv
package dic_pkg;
  localparam int LINES     = 8;
  localparam int IDX_W     = $clog2(LINES);
  localparam int DATA_W    = 8;
  localparam int UNITS     = 2;
  localparam int CASC_LINE = 2;

  // per-controller strobes issued by the control module
  typedef struct packed {
    logic cmdWr;
    logic dataWr;
    logic trigWr;
    logic ack;
  } unitStb_t;

  typedef enum logic [1:0] {RK_CMD, RK_DATA, RK_TRIG} rdKind_e;

  typedef struct packed {
    logic    valid;
    logic    unitSel;
    rdKind_e kind;
  } rdSel_t;

  typedef struct packed {
    logic useSec;
    logic spurious;
  } vecSel_t;

  typedef enum logic [1:0] {INIT_IDLE, INIT_BASE, INIT_W2, INIT_W4} initSt_e;

  // index of lowest set bit (highest priority); LINES when empty
  function automatic logic [IDX_W:0] firstSet(input logic [LINES-1:0] v);
    firstSet = (IDX_W+1)'(LINES);
    for (int i = LINES - 1; i >= 0; i--)
      if (v[i]) firstSet = (IDX_W+1)'(i);
  endfunction
endpackage

// File: rtl/dic_unit.sv
module dic_unit import dic_pkg::*; #(
  parameter logic [LINES-1:0] TRIG_MASK = 8'hF8,
  parameter bit               NEST_OK   = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINES-1:0]  lineIn,
  input  logic [LINES-1:0]  forceSet,
  input  unitStb_t          stb,
  input  logic [DATA_W-1:0] wrByte,
  output logic              want,
  output logic [IDX_W-1:0]  grantIdx,
  output logic [DATA_W-1:0] base,
  output logic [DATA_W-1:0] cmdRd,
  output logic [DATA_W-1:0] maskRd,
  output logic [DATA_W-1:0] trigRd
);
  localparam logic [LINES-1:0]  CASC_BIT  = LINES'(1) << CASC_LINE;
  localparam logic [DATA_W-1:0] BASE_KEEP = ~DATA_W'(LINES - 1);

  logic [LINES-1:0] irr, isr, imr, trig, lastIn;
  logic [LINES-1:0] irrNext, isrNext, grantHot, eoiClr;
  logic [IDX_W:0]   pendPri, curPri, isrPri;
  logic             needW4, nested, readIsr;
  initSt_e          initSt;

  // grant: highest unmasked request above current in-service level
  always_comb begin
    pendPri  = firstSet(irr & ~imr);
    curPri   = firstSet(isr & ~(nested ? CASC_BIT : '0));
    want     = pendPri < curPri;
    grantIdx = pendPri[IDX_W-1:0];
    grantHot = LINES'(1) << grantIdx;
  end

  // end-of-interrupt commands
  always_comb begin
    isrPri = firstSet(isr);
    eoiClr = '0;
    if (stb.cmdWr && !wrByte[4] && !wrByte[3]) begin
      if (wrByte[7:5] == 3'b001 && !isrPri[IDX_W])
        eoiClr = LINES'(1) << isrPri[IDX_W-1:0];
      else if (wrByte[7:5] == 3'b011)
        eoiClr = LINES'(1) << wrByte[IDX_W-1:0];
    end
  end

  // request / in-service next state; acknowledge clear wins over new sets
  always_comb begin
    irrNext = (irr & ~(trig & ~lineIn)) | (~trig & lineIn & ~lastIn)
            | (trig & lineIn) | forceSet;
    if (stb.ack) irrNext = irrNext & ~(grantHot & ~trig);
    isrNext = (isr & ~eoiClr) | (stb.ack ? grantHot : '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irr <= '0; isr <= '0; imr <= '0; trig <= '0; lastIn <= '0;
      base <= '0; needW4 <= 1'b0; nested <= 1'b0; readIsr <= 1'b0;
      initSt <= INIT_IDLE;
    end else begin
      lastIn <= lineIn;
      irr    <= irrNext;
      isr    <= isrNext;
      if (stb.trigWr) trig <= wrByte[LINES-1:0] & TRIG_MASK;
      if (stb.cmdWr && wrByte[4]) begin
        needW4  <= wrByte[0];
        imr     <= '0;
        isr     <= '0;
        irr     <= irr & trig;
        lastIn  <= '0;
        readIsr <= 1'b0;
        if (!wrByte[0]) nested <= 1'b0;
        initSt  <= INIT_BASE;
      end else if (stb.cmdWr && wrByte[3] && wrByte[1]) begin
        readIsr <= wrByte[0];
      end
      if (stb.dataWr) begin
        case (initSt)
          INIT_IDLE: imr <= wrByte[LINES-1:0];
          INIT_BASE: begin base <= wrByte & BASE_KEEP; initSt <= INIT_W2; end
          INIT_W2:   initSt <= needW4 ? INIT_W4 : INIT_IDLE;
          default:   begin nested <= wrByte[4] & NEST_OK; initSt <= INIT_IDLE; end
        endcase
      end
    end
  end

  assign cmdRd  = DATA_W'(readIsr ? isr : irr);
  assign maskRd = DATA_W'(imr);
  assign trigRd = DATA_W'(trig);

  AST_CASC_RELAY: assert property (@(posedge clk) disable iff (!rstN)
    ((|forceSet) && !stb.ack && !stb.cmdWr) |=> ((irr & $past(forceSet)) == $past(forceSet))); // R2
  AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ack && !stb.cmdWr) |=> isr[$past(grantIdx)]); // R4
  AST_ACK_CLEARS_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ack && !stb.cmdWr && !trig[grantIdx]) |=> !irr[$past(grantIdx)]); // R4
  AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    !stb.cmdWr |=> ((irr & $past(trig)) == ($past(lineIn | forceSet) & $past(trig)))); // R7
  AST_WANT_HAS_PEND: assert property (@(posedge clk) disable iff (!rstN)
    want |-> (|(irr & ~imr))); // R10
endmodule

// File: rtl/dic_ctrl.sv
module dic_ctrl import dic_pkg::*; #(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h0020,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h04D0,
  parameter int                SEL_BIT   = 7
) (
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic                       busWr,
  input  logic                       busRd,
  input  logic                       ackStrobe,
  input  logic [UNITS-1:0]           want,
  input  logic [IDX_W-1:0]           pGrant,
  output unitStb_t [UNITS-1:0]       stb,
  output rdSel_t                     rdSel,
  output vecSel_t                    vecSel
);
  localparam logic [ADDR_W-1:0] CTRL_IGN = (ADDR_W'(1) << SEL_BIT) | ADDR_W'(1);
  localparam logic [ADDR_W-1:0] TRIG_IGN = ADDR_W'(1);

  logic ctrlHit, trigHit, ctrlSel, cascGrant;

  always_comb begin
    ctrlHit   = (busAddr & ~CTRL_IGN) == (CTRL_ADDR & ~CTRL_IGN);
    trigHit   = (busAddr & ~TRIG_IGN) == (TRIG_ADDR & ~TRIG_IGN);
    ctrlSel   = busAddr[SEL_BIT];
    cascGrant = want[0] && (pGrant == IDX_W'(CASC_LINE));
    for (int u = 0; u < UNITS; u++) begin
      stb[u].cmdWr  = busWr && ctrlHit && !busAddr[0] && (ctrlSel == 1'(u));
      stb[u].dataWr = busWr && ctrlHit &&  busAddr[0] && (ctrlSel == 1'(u));
      stb[u].trigWr = busWr && trigHit && (busAddr[0] == 1'(u));
    end
    // acknowledge walks the cascade only when the primary grants line 2
    stb[0].ack      = ackStrobe && want[0];
    stb[1].ack      = ackStrobe && cascGrant && want[1];
    vecSel.useSec   = cascGrant;
    vecSel.spurious = !want[0] || (cascGrant && !want[1]);
    rdSel.valid     = busRd && (ctrlHit || trigHit);
    rdSel.unitSel   = ctrlHit ? ctrlSel : busAddr[0];
    rdSel.kind      = trigHit ? RK_TRIG : (busAddr[0] ? RK_DATA : RK_CMD);
  end
endmodule

// File: rtl/dic_datapath.sv
module dic_datapath import dic_pkg::*; #(
  parameter logic [LINES-1:0] PRI_TRIG_MASK = 8'hF8,
  parameter logic [LINES-1:0] SEC_TRIG_MASK = 8'hDE
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [UNITS*LINES-1:0]        irqIn,
  input  unitStb_t [UNITS-1:0]          stb,
  input  logic [DATA_W-1:0]             wrByte,
  input  rdSel_t                        rdSel,
  input  vecSel_t                       vecSel,
  output logic [UNITS-1:0]              want,
  output logic [UNITS-1:0][IDX_W-1:0]   grantIdx,
  output logic [DATA_W-1:0]             rdData,
  output logic [DATA_W-1:0]             ackVector,
  output logic                          intOut
);
  logic [UNITS-1:0][DATA_W-1:0] base, cmdRd, maskRd, trigRd;
  logic [LINES-1:0]             cascSet;
  logic [IDX_W-1:0]             vecLine;

  // secondary demand is relayed as a forced set on primary line 2
  assign cascSet = want[1] ? (LINES'(1) << CASC_LINE) : '0;

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    localparam logic [LINES-1:0] MASK_U = (u == 0) ? PRI_TRIG_MASK : SEC_TRIG_MASK;
    dic_unit #(.TRIG_MASK(MASK_U), .NEST_OK(u == 0)) u_unit (
      .clk      (clk),
      .rstN     (rstN),
      .lineIn   (irqIn[u*LINES +: LINES]),
      .forceSet ((u == 0) ? cascSet : '0),
      .stb      (stb[u]),
      .wrByte   (wrByte),
      .want     (want[u]),
      .grantIdx (grantIdx[u]),
      .base     (base[u]),
      .cmdRd    (cmdRd[u]),
      .maskRd   (maskRd[u]),
      .trigRd   (trigRd[u])
    );
  end

  always_comb begin
    rdData = '0;
    if (rdSel.valid) begin
      case (rdSel.kind)
        RK_CMD:  rdData = cmdRd[rdSel.unitSel];
        RK_DATA: rdData = maskRd[rdSel.unitSel];
        default: rdData = trigRd[rdSel.unitSel];
      endcase
    end
    vecLine   = vecSel.spurious ? IDX_W'(LINES - 1) : grantIdx[vecSel.useSec];
    ackVector = base[vecSel.useSec] | DATA_W'(vecLine);
  end

  assign intOut = want[0];
endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl import dic_pkg::*; #(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h0020,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h04D0,
  parameter int                SEL_BIT   = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       irqIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  input  logic              ackStrobe,
  output logic [7:0]        ackVector,
  output logic              intOut
);
  localparam logic [ADDR_W-1:0] SEC_ADDR = CTRL_ADDR | (ADDR_W'(1) << SEL_BIT);

  unitStb_t [UNITS-1:0]        stb;
  rdSel_t                      rdSel;
  vecSel_t                     vecSel;
  logic [UNITS-1:0]            want;
  logic [UNITS-1:0][IDX_W-1:0] grantIdx;
  logic                        decoded;

  dic_ctrl #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .TRIG_ADDR(TRIG_ADDR),
             .SEL_BIT(SEL_BIT)) u_ctrl (
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd), .ackStrobe(ackStrobe),
    .want(want), .pGrant(grantIdx[0]), .stb(stb), .rdSel(rdSel), .vecSel(vecSel)
  );

  dic_datapath u_dp (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .stb(stb), .wrByte(busWrData),
    .rdSel(rdSel), .vecSel(vecSel), .want(want), .grantIdx(grantIdx),
    .rdData(busRdData), .ackVector(ackVector), .intOut(intOut)
  );

  assign decoded = (busAddr == CTRL_ADDR) || (busAddr == CTRL_ADDR + 1'b1) ||
                   (busAddr == SEC_ADDR)  || (busAddr == SEC_ADDR + 1'b1)  ||
                   (busAddr == TRIG_ADDR) || (busAddr == TRIG_ADDR + 1'b1);

  AST_SPUR_PRI: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && !want[0]) |-> (ackVector[IDX_W-1:0] == '1)); // R6
  AST_SPUR_SEC: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && want[0] && grantIdx[0] == IDX_W'(CASC_LINE) && !want[1])
      |-> (ackVector[IDX_W-1:0] == '1)); // R5
  AST_PRI_VEC_LINE: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && want[0] && grantIdx[0] != IDX_W'(CASC_LINE))
      |-> (ackVector[IDX_W-1:0] == grantIdx[0])); // R4
  AST_UNDECODED_READ: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && !decoded) |-> (busRdData == '0)); // R9
endmodule

// File: tb/sim_dual_irq_ctrl.sv
`timescale 1ns/1ps
module sim_dual_irq_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] irqIn = '0;
  logic [15:0] busAddr = '0;
  logic        busWr = 1'b0, busRd = 1'b0, ackStrobe = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData, ackVector;
  logic        intOut;
  int          nChecks = 0, nFail = 0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;

  dual_irq_ctrl u0 (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .busAddr(busAddr), .busWr(busWr),
    .busRd(busRd), .busWrData(busWrData), .busRdData(busRdData),
    .ackStrobe(ackStrobe), .ackVector(ackVector), .intOut(intOut)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0; busAddr = '0;
  endtask

  task automatic rdChk(input string tag, input logic [15:0] a, input logic [7:0] exp);
    @(negedge clk); busAddr = a; busRd = 1'b1;
    #1 chk(tag, busRdData, exp);
    busRd = 1'b0; busAddr = '0;
  endtask

  task automatic ackChk(input string tag, input logic [7:0] exp);
    @(negedge clk); ackStrobe = 1'b1;
    #1 chk(tag, ackVector, exp);
    @(negedge clk); ackStrobe = 1'b0;
  endtask

  task automatic intChk(input string tag, input logic exp);
    repeat (4) @(negedge clk);
    #1 chk(tag, {7'b0, intOut}, {7'b0, exp});
  endtask

  task automatic setIrq(input int n, input logic v);
    @(negedge clk); irqIn[n] = v;
  endtask

  task automatic tReset;
    #1 chk("R10 reset intOut", {7'b0, intOut}, 8'h00);
    rdChk("R8 reset mask", 16'h0021, 8'h00);
    rdChk("R7 reset trigger", 16'h04D0, 8'h00);
  endtask

  task automatic tInit;
    wr(16'h0020, 8'h11); wr(16'h0021, 8'h08); wr(16'h0021, 8'h04); wr(16'h0021, 8'h01);
    wr(16'h00A0, 8'h11); wr(16'h00A1, 8'h75); wr(16'h00A1, 8'h02); wr(16'h00A1, 8'h01);
  endtask

  task automatic tDecode;
    wr(16'h00A1, 8'h5A);
    rdChk("R8 secondary mask by bit7", 16'h00A1, 8'h5A);
    rdChk("R8 primary mask untouched", 16'h0021, 8'h00);
    wr(16'h00A1, 8'h00);
  endtask

  task automatic tPrimary;
    setIrq(5, 1'b1);
    intChk("R10 primary raise", 1'b1);
    rdChk("R1 primary request bit", 16'h0020, 8'h20);
    ackChk("R4 primary vector", 8'h0D);
    rdChk("R4 edge request cleared", 16'h0020, 8'h00);
    intChk("R10 in-service blocks", 1'b0);
    wr(16'h0020, 8'h0B);
    rdChk("R11 in-service read", 16'h0020, 8'h20);
    wr(16'h0020, 8'h20);
    rdChk("R11 nonspecific EOI", 16'h0020, 8'h00);
    wr(16'h0020, 8'h0A);
    setIrq(5, 1'b0);
  endtask

  task automatic tMask;
    wr(16'h0021, 8'h02);
    setIrq(1, 1'b1);
    intChk("R10 masked line quiet", 1'b0);
    wr(16'h0021, 8'h00);
    intChk("R10 unmask raises", 1'b1);
    ackChk("R4 line1 vector", 8'h09);
    wr(16'h0020, 8'h20);
    setIrq(1, 1'b0);
    intChk("R10 idle after EOI", 1'b0);
  endtask

  task automatic tCascade;
    setIrq(11, 1'b1);
    intChk("R2 secondary raises intOut", 1'b1);
    rdChk("R1 secondary request bit", 16'h00A0, 8'h08);
    rdChk("R2 primary line2 pending", 16'h0020, 8'h04);
    ackChk("R5 cascaded vector, base low bits zeroed (R12)", 8'h73);
    intChk("R5 after cascade ack", 1'b0);
    wr(16'h00A0, 8'h20); wr(16'h0020, 8'h20);
    setIrq(11, 1'b0);
  endtask

  task automatic tSpurSec;
    setIrq(12, 1'b1);
    intChk("R2 line12 raises", 1'b1);
    wr(16'h00A1, 8'h10);
    intChk("R2 line2 stays pending", 1'b1);
    ackChk("R5 secondary spurious", 8'h77);
    wr(16'h0020, 8'h20);
    wr(16'h00A1, 8'h00);
    intChk("R2 unmasked secondary", 1'b1);
    ackChk("R5 line12 vector", 8'h74);
    wr(16'h00A0, 8'h20); wr(16'h0020, 8'h20);
    setIrq(12, 1'b0);
    intChk("R10 idle after line12", 1'b0);
  endtask

  task automatic tSpurPri;
    ackChk("R6 primary spurious", 8'h0F);
    wr(16'h0020, 8'h0B);
    rdChk("R6 no in-service change", 16'h0020, 8'h00);
    wr(16'h0020, 8'h0A);
    intChk("R6 intOut stays low", 1'b0);
  endtask

  task automatic tPreempt;
    setIrq(5, 1'b1);
    intChk("R10 line5 raise", 1'b1);
    ackChk("R4 line5 vector", 8'h0D);
    setIrq(9, 1'b1);
    intChk("R10 secondary preempts line5", 1'b1);
    ackChk("R5 line9 vector", 8'h71);
    setIrq(8, 1'b1);
    intChk("R3 not nested: in-service 2 blocks", 1'b0);
    wr(16'h00A0, 8'h20);
    wr(16'h0020, 8'h20);
    intChk("R11 EOI releases line2", 1'b1);
    ackChk("R5 line8 vector", 8'h70);
    wr(16'h00A0, 8'h20); wr(16'h0020, 8'h20); wr(16'h0020, 8'h20);
    setIrq(5, 1'b0); setIrq(8, 1'b0); setIrq(9, 1'b0);
    intChk("R10 idle after preempt", 1'b0);
  endtask

  task automatic tNested;
    wr(16'h0021, 8'h80);
    wr(16'h0020, 8'h11); wr(16'h0021, 8'h08); wr(16'h0021, 8'h04); wr(16'h0021, 8'h11);
    rdChk("R12 init clears mask", 16'h0021, 8'h00);
    setIrq(11, 1'b1);
    intChk("R2 line11 raise", 1'b1);
    ackChk("R5 line11 vector", 8'h73);
    setIrq(9, 1'b1);
    intChk("R3 nested allows higher secondary", 1'b1);
    ackChk("R3 nested vector", 8'h71);
    wr(16'h00A0, 8'h20); wr(16'h00A0, 8'h20); wr(16'h0020, 8'h20);
    setIrq(9, 1'b0); setIrq(11, 1'b0);
    intChk("R3 idle after nesting", 1'b0);
  endtask

  task automatic tTrig;
    wr(16'h04D0, 8'hFF);
    rdChk("R7 primary trigger mask", 16'h04D0, 8'hF8);
    wr(16'h04D1, 8'hFF);
    rdChk("R7 secondary trigger mask", 16'h04D1, 8'hDE);
    wr(16'h04D1, 8'h00); wr(16'h04D0, 8'h08);
    setIrq(3, 1'b1);
    intChk("R7 level raise", 1'b1);
    ackChk("R7 level vector", 8'h0B);
    rdChk("R7 level request kept", 16'h0020, 8'h08);
    intChk("R7 blocked by own service", 1'b0);
    wr(16'h0020, 8'h63);
    intChk("R11 specific EOI, level re-asserts", 1'b1);
    setIrq(3, 1'b0);
    intChk("R7 level drop", 1'b0);
    rdChk("R7 request follows input", 16'h0020, 8'h00);
    wr(16'h0020, 8'h63);
    wr(16'h04D0, 8'h00);
  endtask

  task automatic tUndecoded;
    wr(16'h0022, 8'hFF); wr(16'h04D2, 8'hFF); wr(16'h00A2, 8'hFF);
    rdChk("R9 mask unchanged", 16'h0021, 8'h00);
    rdChk("R9 secondary mask unchanged", 16'h00A1, 8'h00);
    rdChk("R9 trigger unchanged", 16'h04D0, 8'h00);
    rdChk("R9 undecoded read", 16'h0022, 8'h00);
    rdChk("R9 undecoded read high", 16'h04D2, 8'h00);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset;
    tInit;
    tDecode;
    tPrimary;
    tMask;
    tCascade;
    tSpurSec;
    tSpurPri;
    tPreempt;
    tTrig;
    tUndecoded;
    tNested;
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule